// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of transfers held in small on-chip memories. Software does not have to step in for each word. It writes transmit words and per-entry command words through a simple register port. It sets a first and a last queue index, an optional wrap target and an optional halt, and it sets the serial format and timing. It then writes the start bit. The controller walks the entries in order and drives SCK, MOSI and four chip-select pins. Each received word goes into receive memory at the same index as its entry. At the end of the queue the controller raises a completion flag and, if enabled, an interrupt.

Each command entry holds two things. The first is the chip-select pin levels to drive during that entry. The second is a keep flag that leaves those levels in place through the gap that follows the entry. Word length, clock polarity and phase, the baud divider, the two delays and an internal loopback path are global settings.

The register port accepts one access every cycle and never back-pressures: `reg_we` commits a write on the rising clock edge, and `reg_rdata` follows `reg_addr` combinationally. There is no streaming interface at the block's edge.

Register map (6-bit word address):
- 0x00 format: bit0 clock polarity, bit1 clock phase, bit2 loopback, bits7:4 length code.
- 0x01 divider: bits7:0.
- 0x02 delays: bits7:0 lead delay, bits15:8 gap delay.
- 0x03 queue: bits3:0 first index, bits7:4 last index, bits11:8 wrap target, bit12 wrap enable, bit13 halt enable, bit14 completion interrupt enable, bit15 halt interrupt enable.
- 0x04 control: writing 1 to bit0 starts the queue. Reading bit0 gives busy.
- 0x05 status: bit0 completion and bit1 halted, both cleared by writing 1. Bits7:4 give the current index and are read-only.
- 0x10+i: transmit word i.
- 0x20+i: command i, where bits3:0 are the cs_n levels and bit4 is keep.
- 0x30+i: received word i, read-only.

Top module: `qspi_master`

## Requirements
- R1: After reset, cs_n is 4'hF, sck is 0, irq is 0, and the status and control reads return 0.
- R2: The controller stays idle, with cs_n at 4'hF, until bit0 of control is written. It then processes every entry from the first index to the last index inclusive, in order. The word received for entry N is stored at receive address 0x30+N. The status current index reads the last entry processed.
- R3: With wrap enable set and halt enable clear, finishing the last entry continues at the wrap target. The entries between the last index and the wrap target are not transferred.
- R4: With halt enable set, the controller stops after the last entry even if wrap is enabled. It sets status bit1, and busy reads 0. irq is raised when the halt interrupt enable is set.
- R5: The first SCK edge of an entry comes exactly lead+divider+1 clocks after cs_n takes that entry's levels. When keep is 0, cs_n stays at 4'hF for exactly gap+1 clocks between entries.
- R6: sck idles at the polarity bit. Data leaves MSB first. With phase 0, the receiver samples on the leading edge. With phase 1, it samples on the trailing edge.
- R7: Length code 0 gives 16 bits, codes 8 to 15 give that many bits, and codes 1 to 7 give 8 bits. The received word is right-aligned with zeros above it.
- R8: With loopback set, the receive shifter takes the MOSI bit stream and miso is ignored.
- R9: Each SCK half-period lasts divider clocks. With divider 0, no SCK edge occurs and the queue does not advance until a non-zero divider is written.
- R10: Status bit0 is set at each end of queue and cleared by writing 1 to it. irq is high while it is set and the completion interrupt enable is set.
- R11: During an entry, cs_n carries that entry's levels. When keep is 1, the levels carry directly into the next entry with no idle gap. When keep is 0, cs_n returns to 4'hF after the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select pin levels |
| irq | output | 1 | Interrupt request |

## Verification
The bench covers all four polarity and phase combinations and checks them from both sides: an edge-aware monitor rebuilds the word from the MOSI line, and the receive memory gives the word the shifter captured. A design that samples on the wrong edge, or sends LSB first, returns a shifted or reversed word. The bench uses the short length codes 1 to 7 and code 0. A design that maps these literally would clock 3 or 5 bits, or none at all. Cycle-exact counters measure the lead delay, the half-period and the idle gap, and these catch any off-by-one in the delay counters. Further directed runs cover a stalled divider, a keep-asserted chip select, and the point where wrap is overridden by halt. A controller that gives wrap priority would never stop, and one that ignores the wrap target would fill the skipped receive slots.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int CS_W = 4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_XFER, SQ_GAP} sq_state_e;

  typedef struct packed {
    logic            keep;
    logic [CS_W-1:0] lvl;
  } qcmd_t;

  // length code -> bit count
  function automatic logic [4:0] word_bits(input logic [3:0] code);
    if (code == 4'd0)      return 5'd16;
    else if (code < 4'd8)  return 5'd8;
    else                   return {1'b0, code};
  endfunction
endpackage

// File: rtl/qspi_shifter.sv
module qspi_shifter #(
  parameter int DW   = 16,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            loop,
  input  logic [4:0]      nbits,
  input  logic [DIVW-1:0] div,
  input  logic [DW-1:0]   tx,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rx
);
  logic [DIVW-1:0] hc;
  logic [5:0]      eidx;
  logic            ph;
  logic [DW-1:0]   sh;
  logic            din, tick, lead;
  logic [DW-1:0]   aligned;

  assign aligned = tx << (DW - int'(nbits));
  assign din     = loop ? mosi : miso;
  assign tick    = busy && (hc == div - 1'b1);
  assign lead    = !ph;
  assign sck     = cpol ^ ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; hc <= '0; eidx <= '0; ph <= 1'b0;
      sh <= '0; rx <= '0; mosi <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start && div != '0) begin
          busy <= 1'b1; hc <= '0; eidx <= '0; ph <= 1'b0;
          sh <= aligned; rx <= '0;
          if (!cpha) mosi <= aligned[DW-1];
        end
      end else if (tick) begin
        hc   <= '0;
        ph   <= ~ph;
        eidx <= eidx + 1'b1;
        if (lead ^ cpha) begin
          rx <= {rx[DW-2:0], din};
        end else if (cpha) begin
          mosi <= sh[DW-1];
          sh   <= sh << 1;
        end else begin
          mosi <= sh[DW-2];
          sh   <= sh << 1;
        end
        if (eidx == {nbits, 1'b0} - 6'd1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_pkg::*;
#(
  parameter int PW   = 4,
  parameter int DLYW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            div_nz,
  input  logic [PW-1:0]   first_ptr,
  input  logic [PW-1:0]   last_ptr,
  input  logic [PW-1:0]   wrap_ptr,
  input  logic            wrap_en,
  input  logic            halt_en,
  input  logic [DLYW-1:0] lead_dly,
  input  logic [DLYW-1:0] gap_dly,
  input  qcmd_t           cmd,
  input  logic            sh_done,
  output logic [PW-1:0]   ptr,
  output logic            running,
  output logic            sh_start,
  output logic            rx_we,
  output logic            eoq,
  output logic            halt_evt,
  output logic [CS_W-1:0] cs_n
);
  sq_state_e       st;
  logic [DLYW-1:0] cnt;
  logic            gap_end;

  always_comb begin
    running  = (st != SQ_IDLE);
    sh_start = (st == SQ_LEAD) && (cnt >= lead_dly) && div_nz;
    rx_we    = (st == SQ_XFER) && sh_done;
    gap_end  = (st == SQ_GAP) && (cnt >= gap_dly);
    eoq      = gap_end && (ptr == last_ptr);
    halt_evt = eoq && halt_en;
    case (st)
      SQ_LEAD, SQ_XFER: cs_n = cmd.lvl;
      SQ_GAP:           cs_n = cmd.keep ? cmd.lvl : '1;
      default:          cs_n = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; cnt <= '0; ptr <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (go) begin
          st <= SQ_LEAD; ptr <= first_ptr; cnt <= '0;
        end
        SQ_LEAD: begin
          if (sh_start)             st  <= SQ_XFER;
          else if (cnt < lead_dly)  cnt <= cnt + 1'b1;
        end
        SQ_XFER: if (sh_done) begin
          st <= SQ_GAP; cnt <= '0;
        end
        default: begin
          if (gap_end) begin
            cnt <= '0;
            if (eoq) begin
              if (halt_en)      st <= SQ_IDLE;
              else if (wrap_en) begin ptr <= wrap_ptr; st <= SQ_LEAD; end
              else              st <= SQ_IDLE;
            end else begin
              ptr <= ptr + 1'b1; st <= SQ_LEAD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int QD   = 16,
  parameter int DW   = 16,
  parameter int DIVW = 8,
  parameter int DLYW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [5:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_n,
  output logic        irq
);
  localparam int PW = $clog2(QD);

  logic            cfg_cpol, cfg_cpha, cfg_loop;
  logic [3:0]      cfg_len;
  logic [DIVW-1:0] cfg_div;
  logic [DLYW-1:0] lead_dly, gap_dly;
  logic [PW-1:0]   first_ptr, last_ptr, wrap_ptr;
  logic            wrap_en, halt_en, done_ie, halt_ie;
  logic            done_f, halt_f;

  logic [DW-1:0]   tx_mem  [QD];
  qcmd_t           cmd_mem [QD];
  logic [DW-1:0]   rx_mem  [QD];

  logic [PW-1:0]   ptr;
  logic            running, sh_start, sh_busy, sh_done, rx_we, eoq, halt_evt, go;
  logic [DW-1:0]   sh_rx;
  logic [1:0]      region;
  logic [PW-1:0]   idx;

  assign region = reg_addr[5:4];
  assign idx    = reg_addr[PW-1:0];
  assign go     = reg_we && reg_addr == 6'h04 && reg_wdata[0] && !running;
  assign irq    = (done_f && done_ie) || (halt_f && halt_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cfg_cpol, cfg_cpha, cfg_loop} <= '0;
      cfg_len <= '0; cfg_div <= '0; lead_dly <= '0; gap_dly <= '0;
      first_ptr <= '0; last_ptr <= '0; wrap_ptr <= '0;
      {wrap_en, halt_en, done_ie, halt_ie} <= '0;
      done_f <= 1'b0; halt_f <= 1'b0;
    end else begin
      if (reg_we && region == 2'd0) begin
        case (reg_addr[3:0])
          4'h0: begin
            cfg_cpol <= reg_wdata[0]; cfg_cpha <= reg_wdata[1];
            cfg_loop <= reg_wdata[2]; cfg_len  <= reg_wdata[7:4];
          end
          4'h1: cfg_div <= reg_wdata[DIVW-1:0];
          4'h2: begin lead_dly <= reg_wdata[7:0]; gap_dly <= reg_wdata[15:8]; end
          4'h3: begin
            first_ptr <= reg_wdata[PW-1:0]; last_ptr <= reg_wdata[4+:PW];
            wrap_ptr  <= reg_wdata[8+:PW];
            {halt_ie, done_ie, halt_en, wrap_en} <= reg_wdata[15:12];
          end
          4'h5: begin
            if (reg_wdata[0]) done_f <= 1'b0;
            if (reg_wdata[1]) halt_f <= 1'b0;
          end
          default: ;
        endcase
      end
      if (eoq)      done_f <= 1'b1;
      if (halt_evt) halt_f <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < QD; i++) begin
        tx_mem[i] <= '0; cmd_mem[i] <= '{keep: 1'b0, lvl: '1}; rx_mem[i] <= '0;
      end
    end else begin
      if (reg_we && region == 2'd1) tx_mem[idx]  <= reg_wdata[DW-1:0];
      if (reg_we && region == 2'd2) cmd_mem[idx] <= reg_wdata[CS_W:0];
      if (rx_we)                    rx_mem[ptr]  <= sh_rx;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (region)
      2'd1: reg_rdata = tx_mem[idx];
      2'd2: reg_rdata = 16'(cmd_mem[idx]);
      2'd3: reg_rdata = rx_mem[idx];
      default: case (reg_addr[3:0])
        4'h0: reg_rdata = {8'd0, cfg_len, 1'b0, cfg_loop, cfg_cpha, cfg_cpol};
        4'h1: reg_rdata = 16'(cfg_div);
        4'h2: reg_rdata = {gap_dly, lead_dly};
        4'h3: reg_rdata = {halt_ie, done_ie, halt_en, wrap_en, 4'(wrap_ptr),
                           4'(last_ptr), 4'(first_ptr)};
        4'h4: reg_rdata = {15'd0, running};
        4'h5: reg_rdata = {8'd0, 4'(ptr), 2'd0, halt_f, done_f};
        default: reg_rdata = '0;
      endcase
    endcase
  end

  qspi_seq #(.PW(PW), .DLYW(DLYW)) u_seq (
    .clk, .rst_n, .go, .div_nz(cfg_div != '0),
    .first_ptr, .last_ptr, .wrap_ptr, .wrap_en, .halt_en,
    .lead_dly, .gap_dly, .cmd(cmd_mem[ptr]), .sh_done,
    .ptr, .running, .sh_start, .rx_we, .eoq, .halt_evt, .cs_n
  );

  qspi_shifter #(.DW(DW), .DIVW(DIVW)) u_shift (
    .clk, .rst_n, .start(sh_start), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .loop(cfg_loop), .nbits(word_bits(cfg_len)), .div(cfg_div),
    .tx(tx_mem[ptr]), .miso, .sck, .mosi, .busy(sh_busy), .done(sh_done),
    .rx(sh_rx)
  );
endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk #(
  parameter int DIVW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sck,
  input logic [3:0]      cs_n,
  input logic            running,
  input logic            sh_busy,
  input logic            cfg_cpol,
  input logic [DIVW-1:0] cfg_div,
  input logic            done_f,
  input logic            halt_f,
  input logic            eoq
);
  AST_CS_IDLE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> cs_n == 4'hF); // R11
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> sck == cfg_cpol); // R6
  AST_NO_SCK_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_div == '0 && !sh_busy) |=> !sh_busy); // R9
  AST_SHIFT_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> running); // R2
  AST_DONE_FROM_EOQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> $past(eoq)); // R10
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_f) |-> !running); // R4
endmodule

bind qspi_master qspi_master_chk #(.DIVW(DIVW)) u_chk (
  .clk, .rst_n, .sck, .cs_n, .running, .sh_busy, .cfg_cpol, .cfg_div,
  .done_f, .halt_f, .eoq
);

// File: tb/qspi_master_bench.sv
module qspi_master_bench;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, miso = 1'b1;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic sck, mosi, irq;
  logic [3:0] cs_n;
  int checks = 0, errors = 0;
  logic [15:0] r;

  always #2 clk = ~clk;

  qspi_master u_qspi_master (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
    .reg_rdata, .sck, .mosi, .miso, .cs_n, .irq);

  // {cpol, cpha, loop, len[3:0], pad, tx[15:0], exp_rx[15:0]}
  localparam logic [39:0] VECS [8] = '{
    {1'b0,1'b0,1'b1,4'd8, 1'b0,16'hA5C3,16'h00C3},
    {1'b0,1'b1,1'b1,4'd0, 1'b0,16'h1234,16'h1234},
    {1'b1,1'b0,1'b1,4'd12,1'b0,16'hABCD,16'h0BCD},
    {1'b1,1'b1,1'b1,4'd15,1'b0,16'hFFFE,16'h7FFE},
    {1'b0,1'b0,1'b0,4'd9, 1'b0,16'h0155,16'h01FF},
    {1'b1,1'b1,1'b0,4'd3, 1'b0,16'h00F0,16'h00FF},
    {1'b0,1'b1,1'b0,4'd0, 1'b0,16'h8001,16'hFFFF},
    {1'b1,1'b0,1'b1,4'd5, 1'b0,16'h1E7B,16'h007B}};

  // MOSI monitor: captures on the receiver's sampling edge
  logic cpol_b = 1'b0, cpha_b = 1'b0;
  logic [15:0] mon_sh = '0;
  int mon_cnt = 0;
  always @(sck) begin
    if (((sck != cpol_b) ^ cpha_b)) begin
      mon_sh  = {mon_sh[14:0], mosi};
      mon_cnt = mon_cnt + 1;
    end
  end

  // timing / chip-select monitor, sampled on negedge
  logic tm_en = 1'b0, meas = 1'b0, got = 1'b0, seen = 1'b0, gdone = 1'b0;
  int lat = 0, tcnt = 0, half = 0, hcnt = 0, hmeas = 0, gap = 0;
  logic [3:0] prev_cs = 4'hF;
  logic e_to_d = 1'b0, d_to_f = 1'b0, sck_prev = 1'b0;
  always @(negedge clk) begin
    if (tm_en) begin
      if (!got && !meas && cs_n != 4'hF) begin meas = 1'b1; tcnt = 0; end
      else if (meas) begin
        tcnt++;
        if (sck != cpol_b) begin got = 1'b1; meas = 1'b0; lat = tcnt; hmeas = 1; hcnt = 0; end
      end else if (hmeas == 1) begin
        hcnt++;
        if (sck != sck_prev) begin half = hcnt; hmeas = 2; end
      end
      if (got && cs_n == 4'hF && !gdone) gap++;
      if (got && cs_n != 4'hF && gap > 0) gdone = 1'b1;
    end
    if (prev_cs == 4'hE && cs_n == 4'hD) e_to_d = 1'b1;
    if (prev_cs == 4'hD && cs_n == 4'hF) d_to_f = 1'b1;
    prev_cs  = cs_n;
    sck_prev = sck;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_stat(input int bitn, input string tag);
    logic [15:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(6'h05, s);
      if (s[bitn]) return;
    end
    chk(1'b0, tag, 0, 1);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cycles(3);
    #1 rst_n = 1'b1;
    // R1: reset state
    chk(cs_n == 4'hF, "R1 cs_n", 32'(cs_n), 32'hF);
    chk(sck == 1'b0 && irq == 1'b0, "R1 sck/irq", {sck, irq}, 0);
    rd(6'h05, r); chk(r == 16'h0, "R1 status", r, 0);
    rd(6'h04, r); chk(r == 16'h0, "R1 busy", r, 0);

    // R2: idle until start bit
    wr(6'h01, 16'd2); wr(6'h02, 16'h0000); wr(6'h03, 16'h0000);
    wr(6'h10, 16'h5A5A); wr(6'h20, 16'h000E);
    wait_cycles(20);
    rd(6'h04, r); chk(r == 0 && cs_n == 4'hF, "R2 idle before start", {r, cs_n}, 32'hF);

    // vector table: R6 R7 R8
    for (int v = 0; v < 8; v++) begin
      logic [39:0] e;
      logic [15:0] msk;
      int nb;
      e = VECS[v];
      wr(6'h00, {8'd0, e[36:33], 1'b0, e[37], e[38], e[39]});
      wr(6'h10, e[31:16]);
      wr(6'h05, 16'h0003);
      @(negedge clk);
      cpol_b = e[39]; cpha_b = e[38]; mon_sh = '0; mon_cnt = 0;
      chk(sck == e[39], "R6 idle polarity", sck, e[39]);
      nb  = (e[36:33] == 0) ? 16 : (e[36:33] < 8 ? 8 : int'(e[36:33]));
      msk = (nb == 16) ? 16'hFFFF : 16'((1 << nb) - 1);
      wr(6'h04, 16'h0001);
      wait_stat(0, "R2 vector done");
      rd(6'h30, r);
      chk(r == e[15:0], e[37] ? "R8 loopback rx" : "R7 rx width", r, e[15:0]);
      chk(mon_cnt == nb, "R7 bit count", mon_cnt, nb);
      chk((mon_sh & msk) == (e[31:16] & msk), "R6 mosi order/edge", mon_sh & msk, e[31:16] & msk);
      chk(sck == e[39], "R6 sck back to idle", sck, e[39]);
    end

    // multi-entry queue with keep: R2 R11
    wr(6'h00, 16'h0004); wr(6'h01, 16'd1);
    wr(6'h13, 16'h1111); wr(6'h14, 16'h2222); wr(6'h15, 16'h3333);
    wr(6'h23, 16'h001E); wr(6'h24, 16'h000D); wr(6'h25, 16'h000B);
    wr(6'h03, 16'h0053); wr(6'h05, 16'h0003);
    cpol_b = 1'b0; cpha_b = 1'b0;
    e_to_d = 1'b0; d_to_f = 1'b0;
    wr(6'h04, 16'h0001);
    wait_stat(0, "R2 multi done");
    rd(6'h33, r); chk(r == 16'h1111, "R2 rx entry3", r, 16'h1111);
    rd(6'h34, r); chk(r == 16'h2222, "R2 rx entry4", r, 16'h2222);
    rd(6'h35, r); chk(r == 16'h3333, "R2 rx entry5", r, 16'h3333);
    rd(6'h32, r); chk(r == 16'h0, "R2 entry2 untouched", r, 0);
    rd(6'h36, r); chk(r == 16'h0, "R2 entry6 untouched", r, 0);
    rd(6'h05, r); chk(r[7:4] == 4'd5, "R2 current index", r[7:4], 5);
    chk(e_to_d, "R11 keep carries cs", e_to_d, 1);
    chk(d_to_f, "R11 release without keep", d_to_f, 1);

    // delays, half period, completion irq: R5 R9 R10
    wr(6'h01, 16'd3); wr(6'h02, 16'h0305);
    wr(6'h18, 16'h00AA); wr(6'h19, 16'h0055);
    wr(6'h28, 16'h0007); wr(6'h29, 16'h0007);
    wr(6'h03, 16'h4098); wr(6'h05, 16'h0003);
    tm_en = 1'b1;
    wr(6'h04, 16'h0001);
    wait_stat(0, "R5 delay run done");
    tm_en = 1'b0;
    chk(lat == 9, "R5 lead latency", lat, 9);
    chk(gap == 4, "R5 gap idle clocks", gap, 4);
    chk(half == 3, "R9 half period", half, 3);
    chk(irq == 1'b1, "R10 irq on completion", irq, 1);
    wr(6'h05, 16'h0001);
    rd(6'h05, r);
    chk(r[0] == 1'b0 && irq == 1'b0, "R10 write-one clear", {r[0], irq}, 0);

    // divider zero stall: R9
    wr(6'h01, 16'd0); wr(6'h03, 16'h0000); wr(6'h04, 16'h0001);
    wait_cycles(50);
    rd(6'h05, r); chk(r[0] == 1'b0, "R9 stalled no completion", r[0], 0);
    rd(6'h04, r); chk(r[0] == 1'b1 && sck == 1'b0, "R9 stalled busy, sck idle", {r[0], sck}, 2);
    wr(6'h01, 16'd2);
    wait_stat(0, "R9 resumes");

    // wrap then halt: R3 R4
    wr(6'h05, 16'h0003);
    wr(6'h01, 16'd1); wr(6'h02, 16'h0000);
    wr(6'h1E, 16'hE0E0); wr(6'h1F, 16'hF0F0);
    wr(6'h2E, 16'h000E); wr(6'h2F, 16'h000E); wr(6'h21, 16'h000E);
    wr(6'h03, 16'h1E10);
    wr(6'h04, 16'h0001);
    for (int i = 0; i < 5000; i++) begin
      rd(6'h3F, r);
      if (r != 0) break;
    end
    chk(r == 16'hF0F0, "R3 wrap target reached", r, 16'hF0F0);
    rd(6'h3E, r); chk(r == 16'hE0E0, "R3 wrap entry14", r, 16'hE0E0);
    rd(6'h32, r); chk(r == 16'h0, "R3 skipped entry2", r, 0);
    wr(6'h03, 16'hBE10);
    wait_stat(1, "R4 halt flag");
    wait_cycles(2);
    rd(6'h04, r); chk(r[0] == 1'b0, "R4 stopped", r[0], 0);
    rd(6'h05, r); chk(r[7:4] == 4'd1, "R4 halted at last index", r[7:4], 1);
    chk(irq == 1'b1, "R4 halt irq", irq, 1);
    wr(6'h05, 16'h0003);
    chk(irq == 1'b0 && cs_n == 4'hF, "R4 cleared, cs idle", {irq, cs_n}, 32'hF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule